// File: doc/BRIEF.md
# Data-Ready Triggered Serial ADC Reader

This block is the controller side of a serial link to a delta-sigma converter. The link has three wires and no chip select: the select pin is tied active, so a transfer is framed only by the clock. The converter's serial output pin has two roles. Between reads it signals that a new result is ready by dropping from high to low. After that it carries the result bits. The reader waits on that line, then runs exactly one 16-bit transfer. In that transfer it sends a configuration word out on the data-in line, which may keep the converter in continuous mode. At the same time it collects the signed conversion result from the output line.

The serial clock comes from the system clock. Each half period lasts a parameter number of system clocks. A ratio that would push the serial clock above 4 MHz (period under 250 ns) stops elaboration with an error. The converter changes its output after each falling serial-clock edge. The reader therefore samples on the rising edge, in the middle of each bit, and changes its own data-in bit just after each falling edge. Software-side logic issues a start request and gets back a one-cycle valid pulse with the 16-bit result. An error flag is raised if the converter never signals ready.

Top module: `adc_drdy_spi_reader`

## Requirements
- R1: After reset, the serial clock, data-in, busy, valid and error outputs are all low.
- R2: The serial clock is low whenever busy is low.
- R3: A start request is accepted only when the reader is idle. A request made while waiting for the ready edge or while busy has no effect, so no extra transfer follows.
- R4: After an accepted start, no serial clock is generated until the synchronized data-out line has first been seen high and then seen low. A line that is already low, or stays low after the previous transfer, does not trigger a transfer.
- R5: A transfer has exactly 16 serial-clock periods. Each period is HALF_DIV system clocks low, then HALF_DIV system clocks high, and the first low half starts in the cycle after the ready edge is detected. Elaboration fails if the ratio would make the serial clock faster than 4 MHz.
- R6: The configuration word goes out most significant bit first. Its MSB appears on data-in when busy rises, and each later bit appears right after a falling serial-clock edge. Data-in is low outside a transfer.
- R7: The data-out line is sampled, through a two-stage synchronizer, at each rising serial-clock edge. The first sample is bit 15 of the result and the last is bit 0.
- R8: valid is high for exactly one system clock, in the cycle that follows the 16th falling serial-clock edge. In that cycle the data output holds the 16-bit two's-complement result, and it keeps that value until the next transfer ends.
- R9: busy is high from the cycle after the ready edge is detected until the 16th falling serial-clock edge. It drops in the same cycle that valid rises.
- R10: If no ready edge is detected within TIMEOUT_CYCLES system clocks of an accepted start, the error flag goes high and the reader returns to idle. The next accepted start clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request one read; honoured only when idle |
| cfg_i | input | 16 | Configuration word sent during the transfer |
| dout_drdy_i | input | 1 | Converter data-out line, also the data-ready flag |
| sclk_o | output | 1 | Serial clock to the converter |
| din_o | output | 1 | Serial data to the converter |
| busy_o | output | 1 | A transfer is running |
| data_o | output | 16 | Last signed conversion result |
| valid_o | output | 1 | One-cycle pulse when data_o is updated |
| err_o | output | 1 | No ready edge seen within the timeout |

## Verification
After the ready line falls, the transfer starts three system clocks later: two synchronizer stages plus the state register. The first rising serial-clock edge follows HALF_DIV clocks after that. The bench drives the first result bit a few clocks after the ready edge. It then changes the line only on observed falling serial-clock edges, so every rising-edge sample sees a settled bit. valid and the result are checked on the falling system-clock edge right after the 16th serial-clock fall, and valid is checked low one cycle later. The error flag is sampled one cycle before and one cycle after the clock edge TIMEOUT_CYCLES after the accepting edge.

// File: rtl/adc_rd_pkg.sv
// Shared types for the data-ready triggered serial ADC reader.
// Assumes nothing beyond a synthesizable enum encoding.
package adc_rd_pkg;

    // Controller phases of one read.
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WAIT_HIGH = 2'd1,
        ST_WAIT_FALL = 2'd2,
        ST_SHIFT     = 2'd3
    } rd_state_t;

endpackage

// File: rtl/adc_rd_sync.sv
// Multi-stage synchronizer for an asynchronous single-bit input.
// Assumes STAGES >= 2; RESET_VAL is the idle level of the line.
module adc_rd_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_q;

    // Shift the raw input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/adc_rd_shifter.sv
// Transmit and receive shift registers for one MSB-first serial word.
// Assumes load, advance and sample are single-cycle strobes from the controller.
module adc_rd_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              advance_i,
    input  logic              sample_i,
    input  logic              bit_i,
    output logic              msb_o,
    output logic [WORD_W-1:0] word_o
);

    logic [WORD_W-1:0] tx_q;
    logic [WORD_W-1:0] rx_q;

    // Load the outgoing word, then move it one bit left per falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)         tx_q <= '0;
        else if (load_i)    tx_q <= word_i;
        else if (advance_i) tx_q <= {tx_q[WORD_W-2:0], 1'b0};
    end

    // Collect incoming bits, MSB first, one per rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n)        rx_q <= '0;
        else if (sample_i) rx_q <= {rx_q[WORD_W-2:0], bit_i};
    end

    assign msb_o  = tx_q[WORD_W-1];
    assign word_o = rx_q;

endmodule

// File: rtl/adc_drdy_spi_reader.sv
// Serial master for a converter whose data-out pin doubles as data-ready.
// Waits for the synchronized line to go high and then low, runs one
// 16-period transfer with the serial clock idling low, and returns the result.
// Assumes chip select is tied active outside this block.
module adc_drdy_spi_reader
    import adc_rd_pkg::*;
#(
    parameter int WORD_W         = 16,
    parameter int HALF_DIV       = 32,
    parameter int SYS_CLK_HZ     = 250_000_000,
    parameter int SCLK_MAX_HZ    = 4_000_000,
    parameter int TIMEOUT_CYCLES = 1_000_000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [WORD_W-1:0]        cfg_i,
    input  logic                     dout_drdy_i,
    output logic                     sclk_o,
    output logic                     din_o,
    output logic                     busy_o,
    output logic signed [WORD_W-1:0] data_o,
    output logic                     valid_o,
    output logic                     err_o
);

    localparam int HCW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam int BCW = $clog2(WORD_W);
    localparam int TCW = $clog2(TIMEOUT_CYCLES + 1);

    // Reject a divider that would exceed the converter's clock limit.
    if (64'(SYS_CLK_HZ) > 64'd2 * 64'(HALF_DIV) * 64'(SCLK_MAX_HZ)) begin : g_ratio_bad
        $error("HALF_DIV too small: serial clock would exceed SCLK_MAX_HZ");
    end

    rd_state_t         state_q;
    logic [HCW-1:0]    hcnt_q;
    logic [BCW-1:0]    bitcnt_q;
    logic [TCW-1:0]    tmo_q;
    logic              sclk_q;
    logic              valid_q;
    logic              err_q;
    logic [WORD_W-1:0] data_q;
    logic              line_s;
    logic              tx_msb;
    logic [WORD_W-1:0] rx_word;
    logic              tmo_last;
    logic              ready_edge;
    logic              phase_end;

    adc_rd_sync #(.STAGES(2), .RESET_VAL(1'b1)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (dout_drdy_i),
        .q_o   (line_s)
    );

    // Decode the timeout limit, the ready edge and the end of a half period.
    always_comb begin
        tmo_last   = (tmo_q == TCW'(TIMEOUT_CYCLES - 1));
        ready_edge = (state_q == ST_WAIT_FALL) && !line_s && !tmo_last;
        phase_end  = (state_q == ST_SHIFT) && (hcnt_q == HCW'(HALF_DIV - 1));
    end

    adc_rd_shifter #(.WORD_W(WORD_W)) shift_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (ready_edge),
        .word_i    (cfg_i),
        .advance_i (phase_end && sclk_q),
        .sample_i  (phase_end && !sclk_q),
        .bit_i     (line_s),
        .msb_o     (tx_msb),
        .word_o    (rx_word)
    );

    // Sequence one read: arm, wait high, wait low, then clock 16 bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            hcnt_q   <= '0;
            bitcnt_q <= '0;
            tmo_q    <= '0;
            sclk_q   <= 1'b0;
            valid_q  <= 1'b0;
            err_q    <= 1'b0;
            data_q   <= '0;
        end else begin
            valid_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_WAIT_HIGH;
                        tmo_q   <= '0;
                        err_q   <= 1'b0;
                    end
                end
                ST_WAIT_HIGH, ST_WAIT_FALL: begin
                    if (tmo_last) begin
                        err_q   <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        tmo_q <= tmo_q + 1'b1;
                        if (state_q == ST_WAIT_HIGH && line_s) begin
                            state_q <= ST_WAIT_FALL;
                        end else if (ready_edge) begin
                            state_q  <= ST_SHIFT;
                            hcnt_q   <= '0;
                            bitcnt_q <= '0;
                            sclk_q   <= 1'b0;
                        end
                    end
                end
                ST_SHIFT: begin
                    if (phase_end) begin
                        hcnt_q <= '0;
                        sclk_q <= ~sclk_q;
                        if (sclk_q) begin
                            if (bitcnt_q == BCW'(WORD_W - 1)) begin
                                state_q <= ST_IDLE;
                                valid_q <= 1'b1;
                                data_q  <= rx_word;
                            end else begin
                                bitcnt_q <= bitcnt_q + 1'b1;
                            end
                        end
                    end else begin
                        hcnt_q <= hcnt_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o  = (state_q == ST_SHIFT);
    assign sclk_o  = sclk_q;
    assign din_o   = busy_o & tx_msb;
    assign data_o  = data_q;
    assign valid_o = valid_q;
    assign err_o   = err_q;

endmodule

// File: rtl/adc_rd_checker.sv
// Timing properties of the reader's serial outputs, bound to the top module.
// Assumes the clock and synchronous active-low reset of the reader.
module adc_rd_checker #(
    parameter int HALF_DIV = 32
) (
    input logic clk,
    input logic rst_n,
    input logic sclk_o,
    input logic din_o,
    input logic busy_o,
    input logic valid_o,
    input logic err_o
);

    logic [15:0] lo_cnt;
    logic [15:0] hi_cnt;

    // Count cycles of the low and the high serial-clock phase during a transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_cnt <= '0;
            hi_cnt <= '0;
        end else begin
            lo_cnt <= (busy_o && !sclk_o) ? lo_cnt + 1'b1 : '0;
            hi_cnt <= sclk_o ? hi_cnt + 1'b1 : '0;
        end
    end

    // R2
    sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !sclk_o);

    // R5
    low_half_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_o) |-> (lo_cnt == 16'(HALF_DIV)));

    // R5
    high_half_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk_o) |-> (hi_cnt == 16'(HALF_DIV)));

    // R6
    din_change_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(din_o) |-> ($fell(sclk_o) || $rose(busy_o) || $fell(busy_o)));

    // R8
    valid_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R9
    valid_at_busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $fell(busy_o));

    // R10
    err_outside_transfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> !busy_o);

endmodule

bind adc_drdy_spi_reader adc_rd_checker #(.HALF_DIV(HALF_DIV)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk_o  (sclk_o),
    .din_o   (din_o),
    .busy_o  (busy_o),
    .valid_o (valid_o),
    .err_o   (err_o)
);

// File: tb/adc_drdy_spi_reader_tb_top.sv
// Bench for the reader: models the converter line and checks all outputs.
module adc_drdy_spi_reader_tb_top;

    localparam int HALF = 32;
    localparam int TMO  = 2000;
    localparam int PER  = 4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start_i = 1'b0;
    logic [15:0]        cfg_i = '0;
    logic               line = 1'b1;
    logic               sclk_o;
    logic               din_o;
    logic               busy_o;
    logic signed [15:0] data_o;
    logic               valid_o;
    logic               err_o;

    int n_chk  = 0;
    int n_err  = 0;
    int n_rise = 0;

    adc_drdy_spi_reader #(
        .HALF_DIV(HALF), .TIMEOUT_CYCLES(TMO)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cfg_i(cfg_i),
        .dout_drdy_i(line), .sclk_o(sclk_o), .din_o(din_o), .busy_o(busy_o),
        .data_o(data_o), .valid_o(valid_o), .err_o(err_o)
    );

    always #(PER/2) clk = ~clk;

    always @(posedge sclk_o) n_rise++;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected bit k (0 = first on the wire) of an MSB-first word.
    function automatic logic wire_bit(input logic [15:0] w, input int k);
        return w[15 - k];
    endfunction

    // Expected full period of the serial clock in time units.
    function automatic longint exp_period();
        return longint'(2 * HALF * PER);
    endfunction

    task automatic pulse_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask

    // One read: optional start, ready edge, 16 bits, result checks.
    task automatic do_read(input logic [15:0] res, input logic [15:0] cfg,
                           input bit do_start, input bit end_level, input bit poke);
        logic [15:0] got;
        longint t0, t1;
        got = '0; t0 = 0; t1 = 0;
        cfg_i = cfg;
        line  = 1'b1;
        if (do_start) pulse_start();
        repeat (5) @(negedge clk);
        line = 1'b0;
        repeat (4) @(negedge clk);
        line = wire_bit(res, 0);
        for (int k = 0; k < 16; k++) begin
            @(posedge sclk_o);
            if (k == 0) t0 = $time;
            if (k == 1) t1 = $time;
            got[15 - k] = din_o;
            if (k == 0) chk(busy_o === 1'b1, "R9", "busy during transfer", busy_o, 1);
            if (poke && k == 5) pulse_start();
            @(negedge sclk_o);
            if (k < 15) line = wire_bit(res, k + 1);
            else        line = end_level;
        end
        @(negedge clk);
        chk(valid_o === 1'b1, "R8", "valid after last fall", valid_o, 1);
        chk(data_o === res, "R7", "captured result", data_o, res);
        chk(busy_o === 1'b0, "R9", "busy drops with valid", busy_o, 0);
        chk(sclk_o === 1'b0 && din_o === 1'b0, "R2", "sclk/din idle low",
            {sclk_o, din_o}, 0);
        chk(got === cfg, "R6", "config word on din", got, cfg);
        chk(t1 - t0 == exp_period(), "R5", "serial clock period",
            32'(t1 - t0), 32'(exp_period()));
        chk(err_o === 1'b0, "R10", "no error on good read", err_o, 0);
        @(negedge clk);
        chk(valid_o === 1'b0, "R8", "valid one cycle only", valid_o, 0);
        chk(data_o === res, "R8", "result held", data_o, res);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        int r0;
        logic [15:0] dir_res [5];
        void'($urandom(32'd7321));
        dir_res = '{16'h8000, 16'h7FFF, 16'hFFFF, 16'h0000, 16'h0001};
        repeat (4) @(negedge clk);
        // R1: reset values
        chk({sclk_o, din_o, busy_o, valid_o, err_o} === 5'b0, "R1", "reset outputs",
            {sclk_o, din_o, busy_o, valid_o, err_o}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk({sclk_o, din_o, busy_o, valid_o, err_o} === 5'b0, "R1", "idle after reset",
            {sclk_o, din_o, busy_o, valid_o, err_o}, 0);

        // Directed corner results
        foreach (dir_res[i]) do_read(dir_res[i], ~dir_res[i], 1'b1, 1'b1, 1'b0);

        // R3: start during a transfer is ignored
        do_read(16'h1234, 16'hC3A5, 1'b1, 1'b1, 1'b1);
        r0 = n_rise;
        repeat (10) @(negedge clk);
        line = 1'b0;
        repeat (300) @(negedge clk);
        chk(n_rise == r0 && busy_o === 1'b0, "R3", "no transfer after ignored start",
            n_rise - r0, 0);

        // R4: line left low after a transfer does not trigger
        do_read(16'hA5A5, 16'h5A5A, 1'b1, 1'b0, 1'b0);
        pulse_start();
        r0 = n_rise;
        repeat (300) @(negedge clk);
        chk(n_rise == r0 && busy_o === 1'b0, "R4", "no clock while line stays low",
            n_rise - r0, 0);
        do_read(16'h4321, 16'h0F0F, 1'b0, 1'b1, 1'b0);

        // R10: timeout with the line held high
        line = 1'b1;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        repeat (TMO - 1) @(negedge clk);
        chk(err_o === 1'b0, "R10", "no error before limit", err_o, 0);
        @(negedge clk);
        chk(err_o === 1'b1, "R10", "error at limit", err_o, 1);
        chk(n_rise == r0 + 16 && sclk_o === 1'b0, "R10", "no clock on timeout",
            n_rise - r0, 16);
        do_read(16'h0BAD, 16'h8B83, 1'b1, 1'b1, 1'b0);

        // Random results and configuration words
        for (int n = 0; n < 8; n++) begin
            do_read(16'($urandom), 16'($urandom), 1'b1, 1'b1, 1'b0);
        end

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule